// File: doc/BRIEF.md
# Way-Predicted Data Cache Lookup

This block is the load lookup path of a small four-way set-associative first-level data cache. Each load indexes every way of one set at once. A short slice of the tag, taken from address bits that are available early, then picks the one way whose data is returned. One cycle after the request the block presents that way's word together with an early hit flag. One cycle after that, the full stored tag of the chosen way is compared against the load's address. The block then reports either a confirmed hit or a replay request, which tells the load to issue again.

Early selection only works if the short tag slice identifies at most one line in each set, so the fill port keeps that rule. A new line whose slice matches a resident line in the same set replaces that line. Otherwise it replaces the way named by a round-robin pointer kept for each set. Miss handling and the memory behind the cache lie outside the block: a fill delivers one whole line in a single cycle.

Top module: `wp_dcache_lookup`

## Requirements
- R1: Geometry is 4 ways by 32 sets with 64-byte lines and 32-bit words. Address bits [10:6] select the set, bits [5:2] select the word within the line, and bits [31:11] form the stored tag.
- R2: One cycle after `ld_valid`, `early_valid` is 1. `early_hit` is 1 exactly when a valid line in the selected set has a partial tag equal to address bits [15:12], and in that case `early_way` gives the index of that way (0..3).
- R3: In the same cycle as R2, `early_data` carries the addressed word of the predicted way's line. On an early miss, `early_way` and `early_data` are zero.
- R4: Within any set, no two valid lines ever hold the same partial tag (bits [15:12]).
- R5: A fill replaces the valid line in its set that has the same partial tag, if there is one, and leaves that set's round-robin pointer unchanged. Otherwise it replaces the way named by the pointer and then advances the pointer by one, modulo 4. Every pointer starts at way 0.
- R6: Two cycles after `ld_valid`, `late_valid` is 1. After an early hit, `late_hit` is 1 when the predicted line's stored tag equals address bits [31:11]; otherwise `replay` is 1. The two flags are never high together.
- R7: When no way matches the partial tag, the load is a plain miss: `early_hit`, `late_hit` and `replay` all stay 0.
- R8: While reset is asserted and after it is released, all lines are invalid and every output is 0 until a load is presented.
- R9: A load and a fill presented in the same cycle: the load sees the cache contents as they were before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load request present |
| ld_addr | input | 32 | Load byte address |
| fill_valid | input | 1 | Line fill present |
| fill_addr | input | 32 | Address of the line being filled |
| fill_line | input | 512 | Full line contents, word n in bits [32n+31:32n] |
| early_valid | output | 1 | Early result present (request plus one cycle) |
| early_hit | output | 1 | Partial-tag match found |
| early_way | output | 2 | Predicted way index |
| early_data | output | 32 | Word read from the predicted way |
| late_valid | output | 1 | Late result present (request plus two cycles) |
| late_hit | output | 1 | Full-tag check confirms the prediction |
| replay | output | 1 | Prediction was wrong, so the load must be reissued |

## Verification
Damaged tag or valid state in a set appears on the very next load to that set. It shows as a wrong `early_hit` or `early_way` one cycle after the request, and as a wrong `late_hit` or `replay` one cycle after that. A victim pointer that has drifted shows only after a later non-conflicting fill, when a following load finds its line in an unexpected way or finds an older line already evicted. The bench sweeps every set with distinct, conflicting and foreign partial tags, and compares every field of each load against a model of the replacement rules that it keeps itself.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int unsigned WP_ADDR_W     = 32;
    localparam int unsigned WP_WORD_W     = 32;
    localparam int unsigned WP_WAYS       = 4;
    localparam int unsigned WP_SETS       = 32;
    localparam int unsigned WP_LINE_BYTES = 64;
    localparam int unsigned WP_PT_LSB     = 12;
    localparam int unsigned WP_PT_W       = 4;
endpackage

// File: rtl/wp_tag_store.sv
module wp_tag_store #(
    parameter int unsigned WAYS   = 4,
    parameter int unsigned SETS   = 32,
    parameter int unsigned TAG_W  = 21,
    parameter int unsigned PT_OFF = 1,
    parameter int unsigned PT_W   = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [$clog2(SETS)-1:0]           rd_set,
    input  logic [PT_W-1:0]                   rd_pt,
    output logic [WAYS-1:0]                   rd_match,
    output logic [WAYS-1:0][TAG_W-1:0]        rd_tags,
    input  logic                              fill_en,
    input  logic [$clog2(SETS)-1:0]           fill_set,
    input  logic [TAG_W-1:0]                  fill_tag,
    output logic [$clog2(WAYS)-1:0]           fill_way
);
    localparam int unsigned WAY_W = $clog2(WAYS);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAY_W-1:0]            rr;
    } tstate_t;

    tstate_t          st_q, st_d;
    logic [WAYS-1:0]  fill_hit;
    logic             fill_conf;
    logic [WAY_W-1:0] conf_way;
    logic [PT_W-1:0]  fill_pt;

    assign fill_pt = fill_tag[PT_OFF +: PT_W];

    always_comb begin
        st_d     = st_q;
        rd_match = '0;
        rd_tags  = '0;
        fill_hit = '0;
        conf_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            rd_tags[w]  = st_q.tag[rd_set][w];
            rd_match[w] = st_q.vld[rd_set][w] &&
                          (st_q.tag[rd_set][w][PT_OFF +: PT_W] == rd_pt);
            fill_hit[w] = st_q.vld[fill_set][w] &&
                          (st_q.tag[fill_set][w][PT_OFF +: PT_W] == fill_pt);
            if (fill_hit[w]) conf_way = WAY_W'(w);
        end
        fill_conf = |fill_hit;
        fill_way  = fill_conf ? conf_way : st_q.rr[fill_set];
        if (fill_en) begin
            st_d.vld[fill_set][fill_way] = 1'b1;
            st_d.tag[fill_set][fill_way] = fill_tag;
            if (!fill_conf) st_d.rr[fill_set] = st_q.rr[fill_set] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R4: partial tags stay unique within every set
    always @(posedge clk) begin
        if (!rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int a = 0; a < WAYS; a++) begin
                    for (int b = a + 1; b < WAYS; b++) begin
                        assert_pt_unique_R4: assert (!(st_q.vld[s][a] && st_q.vld[s][b] &&
                            (st_q.tag[s][a][PT_OFF +: PT_W] == st_q.tag[s][b][PT_OFF +: PT_W])))
                            else $error("duplicate partial tag in set %0d", s);
                    end
                end
            end
        end
    end

    assert_rd_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_match));

    assert_fill_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fill_hit));
endmodule

// File: rtl/wp_data_store.sv
module wp_data_store #(
    parameter int unsigned WAYS   = 4,
    parameter int unsigned SETS   = 32,
    parameter int unsigned WORDS  = 16,
    parameter int unsigned WORD_W = 32
) (
    input  logic                              clk,
    input  logic [$clog2(SETS)-1:0]           rd_set,
    input  logic [$clog2(WORDS)-1:0]          rd_word,
    output logic [WAYS-1:0][WORD_W-1:0]       rd_data,
    input  logic                              wr_en,
    input  logic [$clog2(SETS)-1:0]           wr_set,
    input  logic [$clog2(WAYS)-1:0]           wr_way,
    input  logic [WORDS*WORD_W-1:0]           wr_line
);
    localparam int unsigned WAY_W  = $clog2(WAYS);
    localparam int unsigned LINE_W = WORDS * WORD_W;
    localparam int unsigned DEPTH  = SETS * WAYS;

    // Line storage carries no reset: validity lives in the tag store.
    logic [LINE_W-1:0] mem_q [DEPTH];
    logic [LINE_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[{wr_set, wr_way}] = wr_line;
        for (int w = 0; w < WAYS; w++) begin
            rd_data[w] = mem_q[{rd_set, WAY_W'(w)}][rd_word*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end
endmodule

// File: rtl/wp_lookup_pipe.sv
module wp_lookup_pipe #(
    parameter int unsigned WAYS   = 4,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned TAG_W  = 21
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              req_valid,
    input  logic [TAG_W-1:0]                  req_tag,
    input  logic [WAYS-1:0]                   way_match,
    input  logic [WAYS-1:0][TAG_W-1:0]        way_tags,
    input  logic [WAYS-1:0][WORD_W-1:0]       way_data,
    output logic                              early_valid,
    output logic                              early_hit,
    output logic [$clog2(WAYS)-1:0]           early_way,
    output logic [WORD_W-1:0]                 early_data,
    output logic                              late_valid,
    output logic                              late_hit,
    output logic                              replay
);
    localparam int unsigned WAY_W = $clog2(WAYS);

    typedef struct packed {
        logic              ev;
        logic              eh;
        logic [WAY_W-1:0]  ew;
        logic [WORD_W-1:0] ed;
        logic [TAG_W-1:0]  want_tag;
        logic [TAG_W-1:0]  held_tag;
        logic              lv;
        logic              lh;
        logic              rp;
    } pipe_t;

    pipe_t            p_q, p_d;
    logic [WAY_W-1:0] sel;
    logic             any;
    logic             same;

    always_comb begin
        sel = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_match[w]) sel = WAY_W'(w);
        end
        any  = req_valid && (|way_match);
        same = (p_q.want_tag == p_q.held_tag);

        p_d          = p_q;
        p_d.ev       = req_valid;
        p_d.eh       = any;
        p_d.ew       = any ? sel : '0;
        p_d.ed       = any ? way_data[sel] : '0;
        p_d.want_tag = req_tag;
        p_d.held_tag = way_tags[sel];
        p_d.lv       = p_q.ev;
        p_d.lh       = p_q.eh && same;
        p_d.rp       = p_q.eh && !same;
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    assign early_valid = p_q.ev;
    assign early_hit   = p_q.eh;
    assign early_way   = p_q.ew;
    assign early_data  = p_q.ed;
    assign late_valid  = p_q.lv;
    assign late_hit    = p_q.lh;
    assign replay      = p_q.rp;

    assert_early_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> early_valid);

    assert_late_follows_early_R6: assert property (@(posedge clk) disable iff (rst)
        early_valid |=> late_valid);

    assert_replay_needs_hit_R6: assert property (@(posedge clk) disable iff (rst)
        early_hit |=> (late_hit != replay));

    assert_miss_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (early_valid && !early_hit) |=> (!replay && !late_hit));

    assert_miss_zero_data_R3: assert property (@(posedge clk) disable iff (rst)
        !early_hit |-> (early_data == '0 && early_way == '0));
endmodule

// File: rtl/wp_dcache_lookup.sv
module wp_dcache_lookup
    import wp_pkg::*;
#(
    parameter int unsigned ADDR_W     = WP_ADDR_W,
    parameter int unsigned WORD_W     = WP_WORD_W,
    parameter int unsigned WAYS       = WP_WAYS,
    parameter int unsigned SETS       = WP_SETS,
    parameter int unsigned LINE_BYTES = WP_LINE_BYTES,
    parameter int unsigned PT_LSB     = WP_PT_LSB,
    parameter int unsigned PT_W       = WP_PT_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ld_valid,
    input  logic [ADDR_W-1:0]             ld_addr,
    input  logic                          fill_valid,
    input  logic [ADDR_W-1:0]             fill_addr,
    input  logic [LINE_BYTES*8-1:0]       fill_line,
    output logic                          early_valid,
    output logic                          early_hit,
    output logic [$clog2(WAYS)-1:0]       early_way,
    output logic [WORD_W-1:0]             early_data,
    output logic                          late_valid,
    output logic                          late_hit,
    output logic                          replay
);
    localparam int unsigned OFF_W   = $clog2(LINE_BYTES);
    localparam int unsigned SET_W   = $clog2(SETS);
    localparam int unsigned BYTE_W  = $clog2(WORD_W / 8);
    localparam int unsigned WORDS   = LINE_BYTES * 8 / WORD_W;
    localparam int unsigned WSEL_W  = $clog2(WORDS);
    localparam int unsigned TAG_LSB = OFF_W + SET_W;
    localparam int unsigned TAG_W   = ADDR_W - TAG_LSB;
    localparam int unsigned PT_OFF  = PT_LSB - TAG_LSB;
    localparam int unsigned WAY_W   = $clog2(WAYS);

    logic [SET_W-1:0]             ld_set, fl_set;
    logic [WSEL_W-1:0]            ld_word;
    logic [TAG_W-1:0]             ld_tag, fl_tag;
    logic [WAYS-1:0]              match;
    logic [WAYS-1:0][TAG_W-1:0]   tags;
    logic [WAYS-1:0][WORD_W-1:0]  words;
    logic [WAY_W-1:0]             victim;
    logic                         unused_bits;

    assign ld_set      = ld_addr[OFF_W +: SET_W];
    assign ld_word     = ld_addr[BYTE_W +: WSEL_W];
    assign ld_tag      = ld_addr[TAG_LSB +: TAG_W];
    assign fl_set      = fill_addr[OFF_W +: SET_W];
    assign fl_tag      = fill_addr[TAG_LSB +: TAG_W];
    assign unused_bits = ^{ld_addr[BYTE_W-1:0], fill_addr[OFF_W-1:0]};

    wp_tag_store #(
        .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .PT_OFF(PT_OFF), .PT_W(PT_W)
    ) u_tags (
        .clk(clk), .rst(rst),
        .rd_set(ld_set), .rd_pt(ld_addr[PT_LSB +: PT_W]),
        .rd_match(match), .rd_tags(tags),
        .fill_en(fill_valid), .fill_set(fl_set), .fill_tag(fl_tag),
        .fill_way(victim)
    );

    wp_data_store #(
        .WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .WORD_W(WORD_W)
    ) u_data (
        .clk(clk),
        .rd_set(ld_set), .rd_word(ld_word), .rd_data(words),
        .wr_en(fill_valid), .wr_set(fl_set), .wr_way(victim), .wr_line(fill_line)
    );

    wp_lookup_pipe #(
        .WAYS(WAYS), .WORD_W(WORD_W), .TAG_W(TAG_W)
    ) u_pipe (
        .clk(clk), .rst(rst),
        .req_valid(ld_valid), .req_tag(ld_tag),
        .way_match(match), .way_tags(tags), .way_data(words),
        .early_valid(early_valid), .early_hit(early_hit),
        .early_way(early_way), .early_data(early_data),
        .late_valid(late_valid), .late_hit(late_hit), .replay(replay)
    );

    assert_reset_quiet_R8: assert property (@(posedge clk) rst |=> (!early_valid && !late_valid && !replay));

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(late_hit && replay));
endmodule

// File: tb/wp_dcache_lookup_test.sv
`timescale 1ns/1ps
module wp_dcache_lookup_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         ld_valid, fill_valid;
    logic [31:0]  ld_addr, fill_addr;
    logic [511:0] fill_line;
    logic         early_valid, early_hit, late_valid, late_hit, replay;
    logic [1:0]   early_way;
    logic [31:0]  early_data;

    always #4 clk = ~clk;

    wp_dcache_lookup uut (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_line(fill_line),
        .early_valid(early_valid), .early_hit(early_hit), .early_way(early_way),
        .early_data(early_data), .late_valid(late_valid), .late_hit(late_hit),
        .replay(replay)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic        m_vld [32][4];
    logic [20:0] m_tag [32][4];
    logic [1:0]  m_rr  [32];

    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'hA5A5A5A5;
    endfunction

    function automatic logic [31:0] mk(input int up, input int b11, input int pt,
                                       input int set, input int word);
        return {up[15:0], pt[3:0], b11[0], set[4:0], word[3:0], 2'b00};
    endfunction

    task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", msg, act, exp);
        end
    endtask

    task automatic model_fill(input logic [31:0] a);
        int s;
        int v;
        bit conf;
        s = int'(a[10:6]);
        conf = 0;
        v = 0;
        for (int w = 0; w < 4; w++)
            if (m_vld[s][w] && m_tag[s][w][4:1] == a[15:12]) begin conf = 1; v = w; end
        if (!conf) begin v = int'(m_rr[s]); m_rr[s] = m_rr[s] + 2'd1; end
        m_vld[s][v] = 1'b1;
        m_tag[s][v] = a[31:11];
    endtask

    task automatic drive_fill(input logic [31:0] a);
        fill_valid = 1'b1;
        fill_addr  = a;
        for (int w = 0; w < 16; w++)
            fill_line[w*32 +: 32] = pat({a[31:6], 6'b0} + 32'(w * 4));
    endtask

    task automatic apply_fill(input logic [31:0] a);
        @(negedge clk);
        drive_fill(a);
        @(negedge clk);
        fill_valid = 1'b0;
        model_fill(a);
    endtask

    task automatic do_load(input logic [31:0] a, input string lbl,
                           input bit with_fill, input logic [31:0] fa);
        int s;
        bit eh, lh, rp;
        logic [1:0] ew;
        logic [31:0] ed;
        s = int'(a[10:6]);
        eh = 0; ew = 2'd0; ed = 32'd0;
        for (int w = 0; w < 4; w++)
            if (m_vld[s][w] && m_tag[s][w][4:1] == a[15:12]) begin eh = 1; ew = 2'(w); end
        if (eh) ed = pat({m_tag[s][ew], a[10:6], 6'b0} + {26'd0, a[5:2], 2'b00});
        lh = eh && (m_tag[s][ew] == a[31:11]);
        rp = eh && !lh;
        @(negedge clk);
        ld_valid = 1'b1;
        ld_addr  = a;
        if (with_fill) drive_fill(fa);
        @(negedge clk);
        ld_valid   = 1'b0;
        fill_valid = 1'b0;
        if (with_fill) model_fill(fa);
        chk({lbl, " R2 early_valid"}, 32'(early_valid), 32'd1);
        chk({lbl, " R2 early_hit"}, 32'(early_hit), 32'(eh));
        chk({lbl, " R2 R5 early_way"}, 32'(early_way), 32'(ew));
        chk({lbl, " R1 R3 early_data"}, early_data, ed);
        @(negedge clk);
        chk({lbl, " R6 late_valid"}, 32'(late_valid), 32'd1);
        chk({lbl, " R6 late_hit"}, 32'(late_hit), 32'(lh));
        chk({lbl, eh ? " R6 replay" : " R7 replay"}, 32'(replay), 32'(rp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int p [5];
        for (int s = 0; s < 32; s++) begin
            m_rr[s] = 2'd0;
            for (int w = 0; w < 4; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = '0; end
        end
        rst = 1'b1; ld_valid = 1'b0; fill_valid = 1'b0;
        ld_addr = '0; fill_addr = '0; fill_line = '0;
        repeat (3) @(negedge clk);
        chk("R8 reset early_valid", 32'(early_valid), 32'd0);
        chk("R8 reset late_valid", 32'(late_valid), 32'd0);
        chk("R8 reset replay", 32'(replay), 32'd0);
        chk("R8 reset early_data", early_data, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 idle early_valid", 32'(early_valid), 32'd0);
        do_load(mk(1, 0, 0, 0, 0), "R8 empty cache", 0, '0);

        for (int s = 0; s < 32; s++) begin
            for (int k = 0; k < 5; k++) p[k] = (k * 5 + s) % 16;
            for (int k = 0; k < 4; k++) apply_fill(mk(s + 1, 0, p[k], s, 0));
            for (int k = 0; k < 4; k++)
                do_load(mk(s + 1, 0, p[k], s, (k + s) % 16), "R5 rr fill hit", 0, '0);
            do_load(mk(s + 100, 0, p[0], s, 3), "R6 foreign tag", 0, '0);
            do_load(mk(s + 1, 0, p[4], s, 1), "R7 unused partial", 0, '0);
            apply_fill(mk(s + 1, 1, p[2], s, 0));
            do_load(mk(s + 1, 0, p[2], s, 5), "R4 evicted by conflict", 0, '0);
            do_load(mk(s + 1, 1, p[2], s, 5), "R4 conflict line", 0, '0);
            apply_fill(mk(s + 2, 0, p[4], s, 0));
            do_load(mk(s + 1, 0, p[0], s, 2), "R5 rr victim gone", 0, '0);
            do_load(mk(s + 2, 0, p[4], s, 9), "R5 rr new line", 0, '0);
        end

        do_load(mk(2, 0, 4, 0, 7), "R9 load with fill", 1, mk(50, 0, 4, 0, 0));
        do_load(mk(2, 0, 4, 0, 7), "R9 after fill", 0, '0);
        do_load(mk(50, 0, 4, 0, 7), "R9 filled line", 0, '0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule